// File: doc/BRIEF.md
# Four-Master Bus Grant Arbiter

This block decides which of four on-chip bus masters owns a shared bus. Each master raises its own request line. The block answers with a one-hot grant vector, so at most one master holds the bus in any cycle. A master that has been granted keeps the bus for as long as its request stays high. When it drops the request, the block chooses the next owner at the same clock edge, so no idle cycle is inserted.

A mode input selects between two policies:
- **Fixed order:** the lowest-numbered requester wins.
- **Least-recently-granted:** each master has a small saturating counter. The requester with the largest counter wins. Whenever a new grant is issued, the winner's counter drops to zero and every other counter goes up by one.

The counters are kept up to date in both modes, so a change of mode takes effect from correct history. Requests and mode are sampled on the rising clock edge. The grant output is registered and shows the decision from that edge.

Top module: `bus_grant_arbiter`

## Requirements
- R1: While reset is applied, and until the first decision after reset, `grant_o` is all zeros and every priority counter is zero.
- R2: At most one bit of `grant_o` is high in any cycle.
- R3: A grant bit is high only if that master's request was high at the clock edge that produced it. A request on an idle bus is granted at the very next rising edge.
- R4: With `dyn_mode_i` = 0, a new grant goes to the requesting master with the lowest index (bit 0 = master 0 = highest priority).
- R5: While the granted master keeps its request high, `grant_o` stays unchanged, whatever the other requests or the mode do.
- R6: When the granted master drops its request, the next edge issues a new grant among the remaining requesters. If none remain, `grant_o` goes to zero.
- R7: With `dyn_mode_i` = 1, a new grant goes to the requester with the largest counter. Equal counters are resolved in favour of the lower index.
- R8: On every new grant, the winner's counter becomes 0 and every other master's counter increases by one.
- R9: Counters saturate at their maximum (7 with the default 3-bit width) and never wrap to a smaller value except by winning.
- R10: Counters change only at an edge that issues a new grant. While a grant is held, or while no master requests, they stay constant.
- R11: The reset input is asynchronous and active low. Its release is synchronised, so decisions begin on the third rising edge after release.
- R12: Counter bookkeeping runs in fixed mode as well, so the history built in fixed mode governs the first decision after switching to dynamic mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dyn_mode_i | input | 1 | 0 = fixed order, 1 = least-recently-granted |
| req_i | input | 4 | Request line per master, bit i = master i |
| grant_o | output | 4 | One-hot (or zero) registered grant, bit i = master i |

## Verification
The checker enforces these properties on every cycle:
- the grant is one-hot or zero;
- a grant is always traceable to a sampled request;
- a held grant stays stable, and a released bus either hands over or goes idle;
- in fixed mode, the next owner is the lowest-index requester;
- a fresh winner's counter is zero;
- counters stay still while the grant is stable, and a saturated counter stays saturated until it wins.

Some behaviour depends on counter history over many cycles and only the bench scenarios can show it:
- the choice between masters in dynamic mode;
- the lower-index tie-break among equal counters;
- that saturation, not wrap-around, decides who wins;
- that history built in fixed mode carries over into dynamic mode.

// File: rtl/bga_pkg.sv
package bga_pkg;

  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_LRG   = 1'b1
  } arb_mode_e;

endpackage

// File: rtl/bga_rst_sync.sv
module bga_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bga_fixed_pick.sv
module bga_fixed_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] win_oh
);

  logic [N-1:0] blocked;

  // blocked[i] is set when any lower-index master requests
  always_comb begin
    blocked[0] = 1'b0;
    for (int i = 1; i < N; i++) begin
      blocked[i] = blocked[i-1] | req[i-1];
    end
  end

  assign win_oh = req & ~blocked;

endmodule

// File: rtl/bga_lrg_pick.sv
module bga_lrg_pick #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0]        req,
  input  logic [N-1:0][W-1:0] prio,
  output logic [N-1:0]        win_oh
);

  logic [W-1:0] best;
  logic         found;

  // strict greater-than keeps the lower index on ties
  always_comb begin
    win_oh = '0;
    best   = '0;
    found  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || (prio[i] > best))) begin
        found     = 1'b1;
        best      = prio[i];
        win_oh    = '0;
        win_oh[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bga_prio_bank.sv
module bga_prio_bank #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  logic [N-1:0]        win_oh,
  output logic [N-1:0][W-1:0] prio_q
);

  localparam logic [W-1:0] PRIO_MAX = {W{1'b1}};

  logic [N-1:0][W-1:0] prio_d;

  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_comb begin
      if (win_oh[g]) begin
        prio_d[g] = '0;
      end else if (prio_q[g] == PRIO_MAX) begin
        prio_d[g] = PRIO_MAX;
      end else begin
        prio_d[g] = prio_q[g] + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[g] <= '0;
      end else if (upd_en) begin
        prio_q[g] <= prio_d[g];
      end
    end
  end

endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
  import bga_pkg::*;
#(
  parameter int unsigned N_MASTERS = 4,
  parameter int unsigned PRIO_W    = 3,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dyn_mode_i,
  input  logic [N_MASTERS-1:0] req_i,
  output logic [N_MASTERS-1:0] grant_o
);

  logic                              rst_sync_n;
  arb_mode_e                         mode;
  logic [N_MASTERS-1:0]              grant_q;
  logic [N_MASTERS-1:0]              grant_d;
  logic [N_MASTERS-1:0]              fixed_oh;
  logic [N_MASTERS-1:0]              lrg_oh;
  logic [N_MASTERS-1:0]              pick_oh;
  logic [N_MASTERS-1:0][PRIO_W-1:0]  prio_q;
  logic                              owner_holds;
  logic                              grant_en;
  logic                              new_grant;

  bga_rst_sync #(.STAGES(SYNC_LEN)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign mode = arb_mode_e'(dyn_mode_i);

  bga_fixed_pick #(.N(N_MASTERS)) u_fixed (
    .req    (req_i),
    .win_oh (fixed_oh)
  );

  bga_lrg_pick #(.N(N_MASTERS), .W(PRIO_W)) u_lrg (
    .req    (req_i),
    .prio   (prio_q),
    .win_oh (lrg_oh)
  );

  // next-state decision
  always_comb begin
    owner_holds = |(grant_q & req_i);
    pick_oh     = (mode == ARB_LRG) ? lrg_oh : fixed_oh;
    grant_en    = !owner_holds;
    grant_d     = owner_holds ? grant_q : pick_oh;
    new_grant   = !owner_holds && (|req_i);
  end

  // grant register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      grant_q <= '0;
    end else if (grant_en) begin
      grant_q <= grant_d;
    end
  end

  bga_prio_bank #(.N(N_MASTERS), .W(PRIO_W)) u_prio (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .upd_en (new_grant),
    .win_oh (pick_oh),
    .prio_q (prio_q)
  );

  assign grant_o = grant_q;

endmodule

// File: rtl/bga_chk.sv
module bga_chk #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dyn_mode_i,
  input logic [N-1:0]        req_i,
  input logic [N-1:0]        grant_o,
  input logic [N-1:0][W-1:0] prio_q
);

  localparam logic [W-1:0] PRIO_MAX = {W{1'b1}};

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (grant_o == '0 && prio_q == '0);
    end
  end

  // R2
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & req_i) != '0) |=> $stable(grant_o));

  // R6
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & req_i) == '0 && req_i == '0) |=> (grant_o == '0));

  // R6
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & req_i) == '0 && req_i != '0) |=> (grant_o != '0));

  // R4
  fixed_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dyn_mode_i && (grant_o & req_i) == '0 && req_i != '0)
      |=> (grant_o == ($past(req_i) & (~$past(req_i) + 1'b1))));

  // R10
  cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(grant_o) |-> $stable(prio_q));

  for (genvar g = 0; g < N; g++) begin : g_per
    // R3
    grant_traced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[g] |-> $past(req_i[g]));

    // R8
    winner_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o[g] && !$past(grant_o[g])) |-> (prio_q[g] == '0));

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_q[g] == PRIO_MAX)
        |=> (prio_q[g] == PRIO_MAX || (grant_o[g] && !$past(grant_o[g]))));
  end

endmodule

bind bus_grant_arbiter bga_chk #(.N(N_MASTERS), .W(PRIO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .dyn_mode_i (dyn_mode_i),
  .req_i      (req_i),
  .grant_o    (grant_o),
  .prio_q     (prio_q)
);

// File: tb/bus_grant_arbiter_bench.sv
`timescale 1ns/1ps
module bus_grant_arbiter_bench;

  localparam int N   = 4;
  localparam int MAX = 7;

  logic         clk;
  logic         rst_n;
  logic         dyn_mode_i;
  logic [N-1:0] req_i;
  logic [N-1:0] grant_o;

  int n_cmp;
  int n_bad;
  int m_own;
  int m_cnt [N];
  logic [15:0] lfsr;

  bus_grant_arbiter u_bus_grant_arbiter (
    .clk        (clk),
    .rst_n      (rst_n),
    .dyn_mode_i (dyn_mode_i),
    .req_i      (req_i),
    .grant_o    (grant_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic [N-1:0] exp, input string tag);
    n_cmp++;
    if (grant_o !== exp) begin
      n_bad++;
      $display("FAIL %s: grant actual %b expected %b", tag, grant_o, exp);
    end
  endtask

  function automatic logic [N-1:0] model_grant();
    logic [N-1:0] v;
    v = '0;
    if (m_own >= 0) v[m_own] = 1'b1;
    return v;
  endfunction

  // reference model of one clock edge, taken from the requirements
  task automatic model_edge(input logic [N-1:0] r, input logic dm);
    int w;
    int best;
    if (m_own >= 0 && r[m_own]) return;
    w = -1;
    best = -1;
    for (int i = 0; i < N; i++) begin
      if (r[i]) begin
        if (!dm) begin
          if (w < 0) w = i;
        end else if (m_cnt[i] > best) begin
          best = m_cnt[i];
          w = i;
        end
      end
    end
    m_own = w;
    if (w >= 0) begin
      for (int i = 0; i < N; i++) begin
        if (i == w) m_cnt[i] = 0;
        else if (m_cnt[i] < MAX) m_cnt[i] = m_cnt[i] + 1;
      end
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic dm, input string tag);
    req_i = r;
    dyn_mode_i = dm;
    @(posedge clk);
    model_edge(r, dm);
    @(negedge clk);
    check(model_grant(), tag);
  endtask

  task automatic do_reset();
    req_i = '0;
    dyn_mode_i = 1'b0;
    rst_n = 1'b0;
    m_own = -1;
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    check('0, "R1 in reset");
    rst_n = 1'b1;
    // R11: request during synchroniser stages is not yet acted on
    req_i = 4'b1000;
    @(posedge clk);
    @(negedge clk);
    check('0, "R11 sync stage 1");
    req_i = '0;
    @(posedge clk);
    @(negedge clk);
    check('0, "R11 sync stage 2");
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    lfsr  = 16'hACE1;
    do_reset();
    step(4'b0000, 1'b0, "R1 idle after reset");

    // R11/R3: one-edge grant latency
    step(4'b0100, 1'b0, "R3 idle bus granted next edge");
    step(4'b0000, 1'b0, "R6 release to idle");

    // R4: every request pattern in fixed mode
    for (int p = 1; p < 16; p++) begin
      step(p[N-1:0], 1'b0, "R4 fixed lowest index");
      step(4'b0000, 1'b0, "R6 release to idle");
    end

    // R5 / R6 hold and handover
    step(4'b0100, 1'b0, "R5 take");
    step(4'b0101, 1'b0, "R5 hold against higher");
    step(4'b1111, 1'b1, "R5 hold across mode");
    step(4'b0011, 1'b0, "R6 handover");
    step(4'b0000, 1'b0, "R6 idle");

    // R12: fixed-mode history steers dynamic pick
    do_reset();
    step(4'b0001, 1'b0, "R12 fixed grant 0");
    step(4'b0010, 1'b0, "R12 fixed grant 1");
    step(4'b0000, 1'b0, "R12 idle");
    step(4'b0111, 1'b1, "R12 dynamic uses history");
    step(4'b0000, 1'b1, "R12 idle");

    // R7 tie-break from all-zero counters
    do_reset();
    step(4'b1111, 1'b1, "R7 tie lower index");
    step(4'b0000, 1'b1, "R7 idle");

    // R9 saturation decides the winner
    do_reset();
    for (int k = 0; k < 15; k++) step(4'b0001 << (k % 3), 1'b1, "R8 rotate");
    for (int k = 0; k < 5; k++)  step(4'b0001 << (k % 2), 1'b1, "R8 rotate");
    step(4'b0000, 1'b1, "R10 idle no update");
    step(4'b1100, 1'b1, "R9 saturated master wins");
    step(4'b0000, 1'b1, "R9 idle");
    step(4'b1100, 1'b1, "R9 after win counter cleared");
    step(4'b0000, 1'b1, "R9 idle");

    // R10 long hold then contest
    step(4'b0001, 1'b1, "R10 take");
    for (int k = 0; k < 10; k++) step(4'b1111, 1'b1, "R10 hold");
    step(4'b1110, 1'b1, "R10 contest after hold");

    // R7 / R8 sweep with pseudo-random traffic in both modes
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] | (lfsr[4] ? 4'b0 : model_grant()), (k % 500) >= 100,
           "R7 sweep");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule